// File: doc/BRIEF.md
# Accumulator CPU Execution Core

This block is a small multi-cycle processor built around one 24-bit accumulator. It fetches instruction words from a single-port synchronous memory of 1024 words, decodes a fixed set of thirteen operations and runs them. Besides the accumulator it keeps an index register, a program counter, the opcode and mode of the current instruction, a two-bit compare result and a ten-entry stack of return addresses used by subroutine call and return.

The surrounding system loads a program into the memory, releases reset and raises `run`. The core then works until it meets a stop instruction, which raises `halted`, or until it detects a fault, which raises `fault` and reports the reason on `fault_code`. Both conditions last until the next reset. The memory has one cycle of read latency: an address presented in one cycle returns its word in the next one.

Top module: `acc_cpu`

## Requirements
- R1: After reset, `halted`, `fault`, `fault_code`, `cond_code` and `mem_we` are all 0, `mem_addr` is 0, and the first instruction is fetched from word 0.
- R2: The opcode is held in bits 23:16 of an instruction word. Bit 15 selects immediate mode, in which bits 14:0 are the operand, zero-extended. When bit 15 is clear, bit 14 selects indexing, bit 13 selects indirection, and bits 12:0 hold the address.
- R3: The opcodes are LDA 00 (A = word), LDX 04 (X = word), STA 0C (word = A), STX 10 (word = X) and ADD 40 (A = A + word). The addition wraps modulo 2^24.
- R4: An indexed address is the address field plus X. An indirect address is the full word read at the address. When both bits are set, indexing is applied first and indirection second.
- R5: COMP 28 sets `cond_code` from an unsigned comparison of A (left) with the operand (right). The code is 0 when they are equal, 1 when A is less and 2 when A is greater. `cond_code` never takes the value 3.
- R6: TIX 2C adds one to X, wrapping modulo 2^24. It then sets `cond_code` by comparing the new X with the operand, using the encoding of R5.
- R7: LDCH 50 replaces bits 7:0 of A with bits 7:0 of the operand and keeps bits 23:8 of A. STCH 54 rewrites the addressed word so that its bits 7:0 become A[7:0] and its bits 23:8 are unchanged.
- R8: J 3C loads the PC with the effective address, or with the immediate value in immediate mode. JSUB 48 pushes the address of the next instruction and then jumps in the same way. RSUB 4C pops the PC. Calls can nest ten deep.
- R9: HALT FF raises `halted`. From then on the core performs no memory writes and runs no further instructions until reset.
- R10: A fault raises `fault`, sets `fault_code` and stops the core, with no further writes, until reset. The codes are: 1 for an undefined opcode or a store in immediate mode; 2 for an address of 1024 or more, which covers an effective address, an indirect pointer, a jump target and the PC running past the last word; 3 for a JSUB made with ten entries already stacked; 4 for an RSUB made with the stack empty.
- R11: While `run` is low, a core that is waiting to fetch stays where it is, performs no writes and does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Permission to start the next instruction |
| mem_addr | output | 10 | Memory word address |
| mem_wdata | output | 24 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 24 | Memory read data, valid one cycle after the address |
| halted | output | 1 | Set after HALT until reset |
| fault | output | 1 | Set after a detected fault until reset |
| fault_code | output | 3 | Reason for the fault, 0 when there is none |
| cond_code | output | 2 | Result of the last compare |

## Verification
The bench builds the core with its default parameters: 1024 memory words, 24-bit words and a stack depth of ten. At that depth a call chain that exactly fills the stack, and one that goes a single level beyond it, both fit in a short program, so the bench can test the overflow boundary directly. The 1024-word memory also lets a jump to the last word show the program counter running off the end. A 13-bit direct address field that reaches past 1023 gives a simple way to trigger the bad-address trap.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int MEM_WORDS   = 1024,
  parameter int WORD_W      = 24,
  parameter int STACK_DEPTH = 10,
  localparam int AW  = $clog2(MEM_WORDS),
  localparam int SPW = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              halted,
  output logic              fault,
  output logic [2:0]        fault_code,
  output logic [1:0]        cond_code
);
  localparam logic [7:0] OP_LDA  = 8'h00, OP_LDX  = 8'h04, OP_STA  = 8'h0C,
                         OP_STX  = 8'h10, OP_COMP = 8'h28, OP_TIX  = 8'h2C,
                         OP_J    = 8'h3C, OP_ADD  = 8'h40, OP_JSUB = 8'h48,
                         OP_RSUB = 8'h4C, OP_LDCH = 8'h50, OP_STCH = 8'h54,
                         OP_HALT = 8'hFF;
  localparam logic [2:0] FC_OPCODE = 3'd1, FC_ADDR = 3'd2, FC_OVER = 3'd3, FC_UNDER = 3'd4;
  localparam logic [WORD_W:0] LIM  = (WORD_W+1)'(MEM_WORDS);
  localparam logic [AW:0]     LIMP = (AW+1)'(MEM_WORDS);

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_IND, S_INDW, S_OPER, S_EXEC, S_HALT, S_FAULT} state_t;

  state_t            st;
  logic [AW:0]       pc;
  logic [WORD_W-1:0] a, x, ea;
  logic [7:0]        op;
  logic              imm;
  logic [1:0]        cc;
  logic [2:0]        fc;
  logic [SPW-1:0]    sp;
  logic [AW-1:0]     stk [STACK_DEPTH];

  wire [7:0]        op_n    = mem_rdata[WORD_W-1 -: 8];
  wire              imm_n   = mem_rdata[WORD_W-9];
  wire              idx_n   = mem_rdata[WORD_W-10];
  wire              ind_n   = mem_rdata[WORD_W-11];
  wire [WORD_W:0]   ea_n    = (WORD_W+1)'(mem_rdata[WORD_W-12:0]) + (idx_n ? {1'b0, x} : '0);
  wire [WORD_W-1:0] imm_val = WORD_W'(mem_rdata[WORD_W-10:0]);
  wire [WORD_W-1:0] opnd    = imm ? ea : mem_rdata;
  wire [WORD_W-1:0] x_inc   = x + 1'b1;
  wire              ea_bad  = {1'b0, ea} >= LIM;
  wire              stk_full = sp == SPW'(STACK_DEPTH);
  wire legal_n = op_n inside {OP_LDA, OP_LDX, OP_STA, OP_STX, OP_COMP, OP_TIX, OP_J,
                              OP_ADD, OP_JSUB, OP_RSUB, OP_LDCH, OP_STCH, OP_HALT};
  wire store_n = op_n inside {OP_STA, OP_STX, OP_STCH};
  wire push    = st == S_OPER && op == OP_JSUB && !ea_bad && !stk_full;

  function automatic logic [1:0] cmp3(input logic [WORD_W-1:0] l, input logic [WORD_W-1:0] r);
    return (l == r) ? 2'd0 : (l < r) ? 2'd1 : 2'd2;
  endfunction

  assign mem_addr   = (st == S_FETCH) ? pc[AW-1:0] : ea[AW-1:0];
  assign mem_we     = (st == S_OPER && (op == OP_STA || op == OP_STX)) ||
                      (st == S_EXEC && op == OP_STCH);
  assign mem_wdata  = (st == S_EXEC) ? {mem_rdata[WORD_W-1:8], a[7:0]} : (op == OP_STX ? x : a);
  assign halted     = st == S_HALT;
  assign fault      = st == S_FAULT;
  assign fault_code = fc;
  assign cond_code  = cc;

  always_ff @(posedge clk)
    if (push) stk[sp] <= pc[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_FETCH; pc <= '0; a <= '0; x <= '0; ea <= '0;
      op <= '0; imm <= 1'b0; cc <= '0; fc <= '0; sp <= '0;
    end else begin
      case (st)
        S_FETCH: if (run) begin
          if (pc >= LIMP) begin fc <= FC_ADDR; st <= S_FAULT; end
          else begin pc <= pc + 1'b1; st <= S_DEC; end
        end
        S_DEC: begin
          op  <= op_n;
          imm <= imm_n;
          if (!legal_n || (imm_n && store_n)) begin fc <= FC_OPCODE; st <= S_FAULT; end
          else if (op_n == OP_HALT) st <= S_HALT;
          else if (op_n == OP_RSUB) begin
            if (sp == '0) begin fc <= FC_UNDER; st <= S_FAULT; end
            else begin pc <= {1'b0, stk[sp - 1'b1]}; sp <= sp - 1'b1; st <= S_FETCH; end
          end
          else if (imm_n) begin ea <= imm_val; st <= S_OPER; end
          else if (ea_n >= LIM) begin fc <= FC_ADDR; st <= S_FAULT; end
          else begin ea <= ea_n[WORD_W-1:0]; st <= ind_n ? S_IND : S_OPER; end
        end
        S_IND: st <= S_INDW;
        S_INDW: begin
          if ({1'b0, mem_rdata} >= LIM) begin fc <= FC_ADDR; st <= S_FAULT; end
          else begin ea <= mem_rdata; st <= S_OPER; end
        end
        S_OPER: case (op)
          OP_STA, OP_STX: st <= S_FETCH;
          OP_J: begin
            if (ea_bad) begin fc <= FC_ADDR; st <= S_FAULT; end
            else begin pc <= {1'b0, ea[AW-1:0]}; st <= S_FETCH; end
          end
          OP_JSUB: begin
            if (ea_bad) begin fc <= FC_ADDR; st <= S_FAULT; end
            else if (stk_full) begin fc <= FC_OVER; st <= S_FAULT; end
            else begin pc <= {1'b0, ea[AW-1:0]}; sp <= sp + 1'b1; st <= S_FETCH; end
          end
          default: st <= S_EXEC;
        endcase
        S_EXEC: begin
          case (op)
            OP_LDA:  a <= opnd;
            OP_LDX:  x <= opnd;
            OP_ADD:  a <= a + opnd;
            OP_LDCH: a[7:0] <= opnd[7:0];
            OP_COMP: cc <= cmp3(a, opnd);
            OP_TIX:  begin x <= x_inc; cc <= cmp3(x_inc, opnd); end
            default: ;
          endcase
          st <= S_FETCH;
        end
        default: ;
      endcase
    end
  end
endmodule

module acc_cpu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_we,
  input logic       halted,
  input logic       fault,
  input logic [2:0] fault_code,
  input logic [1:0] cond_code
);
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted); // R9
  AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) (halted || fault) |-> !mem_we); // R9
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) fault |=> fault && $stable(fault_code)); // R10
  AST_CODE_ONLY_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n) !fault |-> fault_code == 3'd0); // R10
  AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) fault |-> (fault_code != 3'd0 && fault_code <= 3'd4)); // R10
  AST_STOP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(halted && fault)); // R10
  AST_CC_ENCODED: assert property (@(posedge clk) disable iff (!rst_n) cond_code != 2'd3); // R5
endmodule

bind acc_cpu acc_cpu_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .halted(halted),
  .fault(fault), .fault_code(fault_code), .cond_code(cond_code)
);

// File: tb/acc_cpu_tb_top.sv
module acc_cpu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [9:0]  mem_addr;
  logic [23:0] mem_wdata;
  logic        mem_we;
  logic [23:0] mem_rdata = '0;
  logic        halted, fault;
  logic [2:0]  fault_code;
  logic [1:0]  cond_code;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  typedef struct { logic [9:0] addr; logic [23:0] data; string req; } wr_t;
  wr_t exp_q[$];

  logic [23:0] mem [1024];

  always #10 clk = ~clk;

  acc_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted), .fault(fault),
    .fault_code(fault_code), .cond_code(cond_code)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic expect_wr(input int unsigned addr, input logic [23:0] data, input string req);
    wr_t e;
    e.addr = 10'(addr); e.data = data; e.req = req;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0)
        check(0, cur_req, $sformatf("write addr=%0d data=%h, expected no write", mem_addr, mem_wdata));
      else begin
        wr_t e;
        e = exp_q.pop_front();
        check(mem_addr == e.addr && mem_wdata == e.data, e.req,
              $sformatf("write addr=%0d data=%h, expected addr=%0d data=%h",
                        mem_addr, mem_wdata, e.addr, e.data));
      end
    end
  end

  function automatic logic [23:0] ins(input logic [7:0] op, input bit ix, input bit ind, input int unsigned adr);
    return {op, 1'b0, ix, ind, 13'(adr)};
  endfunction
  function automatic logic [23:0] insi(input logic [7:0] op, input int unsigned v);
    return {op, 1'b1, 15'(v)};
  endfunction
  localparam logic [23:0] HALT_W = 24'hFF0000;
  localparam logic [23:0] RSUB_W = 24'h4C0000;

  task automatic hold_reset(input string req);
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0;
    exp_q.delete();
    cur_req = req;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_until_stop(input string req);
    int n = 0;
    run = 1'b1;
    while (!(halted || fault) && n < 3000) begin @(negedge clk); n++; end
    check(halted || fault, req, $sformatf("halted=%0b fault=%0b, expected a stop", halted, fault));
    check(exp_q.size() == 0, req, $sformatf("%0d writes missing, expected 0", exp_q.size()));
  endtask

  task automatic end_state(input string req, input bit exp_halt, input logic [2:0] exp_code);
    check(halted == exp_halt && fault == (exp_code != 0) && fault_code == exp_code, req,
          $sformatf("halted=%0b fault=%0b code=%0d, expected halted=%0b code=%0d",
                    halted, fault, fault_code, exp_halt, exp_code));
  endtask

  task automatic cc_case(input logic [23:0] w0, input logic [23:0] w1, input logic [1:0] exp_cc, input string req);
    hold_reset(req);
    mem[0] = w0; mem[1] = w1; mem[2] = HALT_W;
    mem[500] = 24'd7; mem[501] = 24'h800000; mem[502] = 24'hFFFFFF;
    release_reset();
    run_until_stop(req);
    check(cond_code == exp_cc, req, $sformatf("cond_code=%0d, expected %0d", cond_code, exp_cc));
  endtask

  initial begin
    // R1, R11, R3, R2: basic program, held with run low first
    hold_reset("R1");
    mem[0] = ins(8'h00, 0, 0, 100);
    mem[1] = ins(8'h40, 0, 0, 101);
    mem[2] = ins(8'h0C, 0, 0, 200);
    mem[3] = insi(8'h04, 5);
    mem[4] = ins(8'h10, 0, 0, 201);
    mem[5] = ins(8'h40, 0, 0, 102);
    mem[6] = ins(8'h0C, 0, 0, 202);
    mem[7] = HALT_W;
    mem[100] = 24'h123456; mem[101] = 24'h000111; mem[102] = 24'hFFFFFF;
    release_reset();
    check(!halted && !fault && fault_code == 0 && cond_code == 0 && !mem_we && mem_addr == 0, "R1",
          $sformatf("h=%0b f=%0b code=%0d cc=%0d we=%0b addr=%0d, expected all 0",
                    halted, fault, fault_code, cond_code, mem_we, mem_addr));
    cur_req = "R11";
    repeat (20) @(negedge clk);
    check(mem[200] == 0 && !halted && mem_addr == 0, "R11",
          $sformatf("mem[200]=%h halted=%0b addr=%0d, expected 0/0/0", mem[200], halted, mem_addr));
    cur_req = "R3";
    expect_wr(200, 24'h123567, "R3");
    expect_wr(201, 24'd5, "R2");
    expect_wr(202, 24'h123566, "R3");
    run_until_stop("R3");
    end_state("R3", 1, 0);

    // R4: addressing modes
    hold_reset("R4");
    mem[0] = insi(8'h04, 3);
    mem[1] = ins(8'h00, 1, 0, 300);
    mem[2] = ins(8'h0C, 0, 0, 210);
    mem[3] = ins(8'h00, 0, 1, 310);
    mem[4] = ins(8'h0C, 0, 0, 211);
    mem[5] = ins(8'h00, 1, 1, 330);
    mem[6] = ins(8'h0C, 0, 0, 212);
    mem[7] = ins(8'h0C, 1, 0, 400);
    mem[8] = HALT_W;
    mem[303] = 24'hAAAAAA; mem[310] = 24'd320; mem[320] = 24'h0BBBBB;
    mem[333] = 24'd340; mem[340] = 24'h00CCCC;
    release_reset();
    expect_wr(210, 24'hAAAAAA, "R4");
    expect_wr(211, 24'h0BBBBB, "R4");
    expect_wr(212, 24'h00CCCC, "R4");
    expect_wr(403, 24'h00CCCC, "R4");
    run_until_stop("R4");
    end_state("R4", 1, 0);

    // R5: compare encoding, unsigned
    cc_case(insi(8'h00, 7), ins(8'h28, 0, 0, 500), 2'd0, "R5");
    cc_case(insi(8'h00, 7), insi(8'h28, 9), 2'd1, "R5");
    cc_case(ins(8'h00, 0, 0, 501), insi(8'h28, 9), 2'd2, "R5");
    // R6: increment then compare
    cc_case(insi(8'h04, 4), insi(8'h2C, 4), 2'd2, "R6");
    cc_case(insi(8'h04, 4), insi(8'h2C, 6), 2'd1, "R6");
    hold_reset("R6");
    mem[0] = ins(8'h04, 0, 0, 502);
    mem[1] = insi(8'h2C, 0);
    mem[2] = ins(8'h10, 0, 0, 221);
    mem[3] = HALT_W;
    mem[502] = 24'hFFFFFF;
    release_reset();
    expect_wr(221, 24'd0, "R6");
    run_until_stop("R6");
    check(cond_code == 0, "R6", $sformatf("cond_code=%0d, expected 0", cond_code));

    // R7: byte load and store
    hold_reset("R7");
    mem[0] = ins(8'h00, 0, 0, 600);
    mem[1] = ins(8'h50, 0, 0, 601);
    mem[2] = ins(8'h0C, 0, 0, 230);
    mem[3] = ins(8'h54, 0, 0, 231);
    mem[4] = insi(8'h50, 24'h1FF);
    mem[5] = ins(8'h0C, 0, 0, 232);
    mem[6] = HALT_W;
    mem[600] = 24'hABCDEF; mem[601] = 24'h123456; mem[231] = 24'h777777;
    release_reset();
    expect_wr(230, 24'hABCD56, "R7");
    expect_wr(231, 24'h777756, "R7");
    expect_wr(232, 24'hABCDFF, "R7");
    run_until_stop("R7");
    end_state("R7", 1, 0);

    // R8: call, return, jump
    hold_reset("R8");
    mem[0] = ins(8'h48, 0, 0, 20);
    mem[1] = ins(8'h0C, 0, 0, 240);
    mem[2] = ins(8'h3C, 0, 0, 30);
    mem[3] = 24'h010000;
    mem[20] = insi(8'h00, 24'h42);
    mem[21] = RSUB_W;
    mem[30] = insi(8'h00, 9);
    mem[31] = ins(8'h0C, 0, 0, 241);
    mem[32] = HALT_W;
    release_reset();
    expect_wr(240, 24'h42, "R8");
    expect_wr(241, 24'd9, "R8");
    run_until_stop("R8");
    end_state("R8", 1, 0);

    // R8: ten nested calls fill the stack exactly
    hold_reset("R8");
    mem[0] = ins(8'h48, 0, 0, 50);
    mem[1] = ins(8'h0C, 0, 0, 250);
    mem[2] = HALT_W;
    for (int i = 0; i < 10; i++) begin
      mem[50 + 2*i] = (i < 9) ? ins(8'h48, 0, 0, 52 + 2*i) : insi(8'h00, 24'h99);
      mem[51 + 2*i] = RSUB_W;
    end
    release_reset();
    expect_wr(250, 24'h99, "R8");
    run_until_stop("R8");
    end_state("R8", 1, 0);

    // R10: eleventh call overflows
    hold_reset("R10");
    mem[0] = ins(8'h48, 0, 0, 50);
    mem[1] = ins(8'h0C, 0, 0, 250);
    mem[2] = HALT_W;
    for (int i = 0; i < 11; i++) begin
      mem[50 + 2*i] = (i < 10) ? ins(8'h48, 0, 0, 52 + 2*i) : insi(8'h00, 24'h99);
      mem[51 + 2*i] = RSUB_W;
    end
    release_reset();
    run_until_stop("R10");
    end_state("R10", 0, 3'd3);

    // R9: halt is sticky and blocks later stores
    hold_reset("R9");
    mem[0] = insi(8'h00, 1);
    mem[1] = HALT_W;
    mem[2] = ins(8'h0C, 0, 0, 260);
    release_reset();
    run_until_stop("R9");
    repeat (30) @(negedge clk);
    end_state("R9", 1, 0);
    check(mem[260] == 0, "R9", $sformatf("mem[260]=%h, expected 0", mem[260]));

    // R10: undefined opcode after a good store, then stays faulted
    hold_reset("R10");
    mem[0] = insi(8'h00, 5);
    mem[1] = ins(8'h0C, 0, 0, 270);
    mem[2] = 24'h080000;
    release_reset();
    expect_wr(270, 24'd5, "R10");
    run_until_stop("R10");
    repeat (20) @(negedge clk);
    end_state("R10", 0, 3'd1);

    hold_reset("R10"); mem[0] = insi(8'h0C, 3); release_reset();
    run_until_stop("R10"); end_state("R10", 0, 3'd1);

    hold_reset("R10"); mem[0] = ins(8'h00, 0, 0, 24'h1400); release_reset();
    run_until_stop("R10"); end_state("R10", 0, 3'd2);

    hold_reset("R10"); mem[0] = insi(8'h04, 24'h7FFF); mem[1] = ins(8'h00, 1, 0, 0); release_reset();
    run_until_stop("R10"); end_state("R10", 0, 3'd2);

    hold_reset("R10"); mem[0] = ins(8'h00, 0, 1, 10); mem[10] = 24'h000400; release_reset();
    run_until_stop("R10"); end_state("R10", 0, 3'd2);

    hold_reset("R10"); mem[0] = RSUB_W; release_reset();
    run_until_stop("R10"); end_state("R10", 0, 3'd4);

    hold_reset("R10"); mem[0] = insi(8'h3C, 24'h500); release_reset();
    run_until_stop("R10"); end_state("R10", 0, 3'd2);

    hold_reset("R10"); mem[0] = ins(8'h3C, 0, 0, 1023); mem[1023] = insi(8'h00, 1); release_reset();
    run_until_stop("R10"); end_state("R10", 0, 3'd2);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end
endmodule